// File: doc/BRIEF.md
# Predicated Taint-Tracking Register Datapath

This block executes a small restricted instruction set in which no instruction can change the flow of control. A conditional is written as a compare that sets a one-bit predicate. Later moves, loads and stores can name that predicate as their guard. Each general register, the predicate and every word of a small direct-addressed data memory carries a one-bit label: 0 means trusted or public, and 1 means tainted or secret. Data and labels are updated together as each instruction retires, so a dependence on secret data shows up as a label on the state that was written. The program counter stays clean.

One instruction is presented per cycle, together with `instr_valid_i` and a label bit `instr_lbl_i`. That label bit marks the immediate field, which is also the memory address, as tainted. State changes on the clock edge that samples the instruction. The register and memory contents can be read back through combinational debug ports. Forbidden encodings raise a one-cycle flag, and the instruction then does nothing except advance the program counter.

Top module: `pred_taint_core`

## Requirements
- R1: After reset, every register value and label, the predicate and its label, every memory word and its label, the program counter, `pc_taint_o` and `illegal_o` are all zero.
- R2: The instruction word is {op[20:18], pbit[17], rd[16:14], rs[13:11], rt[10:8], imm[7:0]}, and the memory address is imm[3:0]. A move-immediate (op 1) with pbit 0 writes imm to rd and gives rd the label `instr_lbl_i`, whatever the predicate label is.
- R3: A compare (op 3, pbit 0) sets the predicate to (r[rs] == r[rt]) and sets the predicate label to label(rs) OR label(rt).
- R4: A move-immediate, a register move (op 2: rd = r[rs]) or a load with pbit 1 and a true predicate writes its value to rd. The label of rd becomes the source label ORed with the predicate label.
- R5: When one of those instructions has pbit 1 and a false predicate, rd keeps its value. The label of rd becomes its old label ORed with the predicate label.
- R6: A load (op 4) writes mem[addr] to rd with the label mem-label(addr) OR `instr_lbl_i`, and the predicate label is ORed in when pbit is 1.
- R7: A store (op 5) with a true guard, or with no guard, writes r[rs] to mem[addr] with the label label(rs) OR `instr_lbl_i` OR (predicate label when pbit is 1). With a false guard the word keeps its value and its label becomes old OR predicate label.
- R8: Every valid instruction, legal or illegal, raises the program counter by exactly 1. `pc_taint_o` is never 1.
- R9: Op 6 (jump), op 7 (register-indirect load) and a compare with pbit 1 are illegal. They raise `illegal_o` in the next cycle and change no register, label, predicate or memory word.
- R10: In a cycle with `instr_valid_i` low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 21 | Instruction word |
| instr_lbl_i | input | 1 | Label of the immediate/address field |
| dbg_reg_sel_i | input | 3 | Register selected for read-back |
| dbg_mem_sel_i | input | 4 | Memory word selected for read-back |
| pc_o | output | 8 | Program counter |
| pc_taint_o | output | 1 | Label of the program counter |
| illegal_o | output | 1 | Previous instruction was rejected |
| pred_o | output | 1 | Predicate value |
| pred_lbl_o | output | 1 | Predicate label |
| reg_lbls_o | output | 8 | Labels of all registers, bit i for register i |
| dbg_reg_data_o | output | 8 | Value of the selected register |
| dbg_reg_lbl_o | output | 1 | Label of the selected register |
| dbg_mem_data_o | output | 8 | Value of the selected memory word |
| dbg_mem_lbl_o | output | 1 | Label of the selected memory word |

## Verification
On every cycle the assertions check the program-counter step and its clean label, the frozen state on idle and illegal cycles, the move-immediate label, the compare label, and the rule that a guarded write never clears a label. Values cannot be seen by those properties: the data that moves, the guarded store that is held back, and a tainted address turning a clean memory word into a tainted load. Only the bench's short programs show those, because they compare every register, the predicate and selected memory words against an independent model after each instruction.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MOVI = 3'd1,
    OP_MOV  = 3'd2,
    OP_CMP  = 3'd3,
    OP_LD   = 3'd4,
    OP_ST   = 3'd5,
    OP_JMP  = 3'd6,
    OP_LDR  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_MEM = 2'd2
  } src_e;
endpackage

// File: rtl/ptt_decode.sv
module ptt_decode
  import ptt_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 3,
  parameter int AW = 4,
  localparam int IW = 3 + 1 + 3 * RW + DW
) (
  input  logic [IW-1:0] instr_i,
  output logic          pbit_o,
  output logic [RW-1:0] rd_o,
  output logic [RW-1:0] rs_o,
  output logic [RW-1:0] rt_o,
  output logic [DW-1:0] imm_o,
  output logic [AW-1:0] addr_o,
  output src_e          src_o,
  output logic          wr_reg_o,
  output logic          wr_mem_o,
  output logic          wr_pred_o,
  output logic          illegal_o
);
  localparam int OP_LSB = IW - 3;
  localparam int PB_POS = OP_LSB - 1;
  localparam int RD_LSB = PB_POS - RW;
  localparam int RS_LSB = RD_LSB - RW;
  localparam int RT_LSB = RS_LSB - RW;

  op_e op;

  assign op     = op_e'(instr_i[IW-1:OP_LSB]);
  assign pbit_o = instr_i[PB_POS];
  assign rd_o   = instr_i[RD_LSB +: RW];
  assign rs_o   = instr_i[RS_LSB +: RW];
  assign rt_o   = instr_i[RT_LSB +: RW];
  assign imm_o  = instr_i[DW-1:0];
  assign addr_o = instr_i[AW-1:0];

  always_comb begin
    src_o     = SRC_IMM;
    wr_reg_o  = 1'b0;
    wr_mem_o  = 1'b0;
    wr_pred_o = 1'b0;
    illegal_o = 1'b0;
    case (op)
      OP_MOVI: wr_reg_o = 1'b1;
      OP_MOV: begin
        wr_reg_o = 1'b1;
        src_o    = SRC_REG;
      end
      OP_LD: begin
        wr_reg_o = 1'b1;
        src_o    = SRC_MEM;
      end
      OP_ST:  wr_mem_o = 1'b1;
      OP_CMP: begin
        // a guarded compare would make the predicate depend on itself
        wr_pred_o = ~pbit_o;
        illegal_o = pbit_o;
      end
      OP_JMP, OP_LDR: illegal_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptt_regfile.sv
module ptt_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen_i,
  input  logic [RW-1:0]   waddr_i,
  input  logic            wdata_en_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wlbl_i,
  input  logic [RW-1:0]   ra_a_i,
  input  logic [RW-1:0]   ra_b_i,
  input  logic [RW-1:0]   ra_c_i,
  input  logic [RW-1:0]   ra_d_i,
  output logic [DW-1:0]   rd_a_o,
  output logic            rl_a_o,
  output logic [DW-1:0]   rd_b_o,
  output logic            rl_b_o,
  output logic            rl_c_o,
  output logic [DW-1:0]   rd_d_o,
  output logic            rl_d_o,
  output logic [NREG-1:0] lbls_o
);
  logic [DW-1:0] val_q [NREG];
  logic [NREG-1:0] lbl_q;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic hit;
    logic [DW-1:0] val_d;
    logic lbl_d;
    assign hit = wen_i && (waddr_i == RW'(g));

    always_comb begin
      val_d = val_q[g];
      lbl_d = lbl_q[g];
      if (hit) begin
        lbl_d = wlbl_i;
        if (wdata_en_i) val_d = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[g] <= '0;
        lbl_q[g] <= 1'b0;
      end else if (hit) begin
        val_q[g] <= val_d;
        lbl_q[g] <= lbl_d;
      end
    end
  end

  assign rd_a_o = val_q[ra_a_i];
  assign rl_a_o = lbl_q[ra_a_i];
  assign rd_b_o = val_q[ra_b_i];
  assign rl_b_o = lbl_q[ra_b_i];
  assign rl_c_o = lbl_q[ra_c_i];
  assign rd_d_o = val_q[ra_d_i];
  assign rl_d_o = lbl_q[ra_d_i];
  assign lbls_o = lbl_q;
endmodule

// File: rtl/ptt_dmem.sv
module ptt_dmem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wdata_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wlbl_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rlbl_o,
  output logic [DW-1:0] dbg_data_o,
  output logic          dbg_lbl_o
);
  logic [DW-1:0] word_q [DEPTH];
  logic [DEPTH-1:0] lbl_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    logic [DW-1:0] word_d;
    assign hit    = wen_i && (addr_i == AW'(g));
    assign word_d = wdata_en_i ? wdata_i : word_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
        lbl_q[g]  <= 1'b0;
      end else if (hit) begin
        word_q[g] <= word_d;
        lbl_q[g]  <= wlbl_i;
      end
    end
  end

  assign rdata_o    = word_q[addr_i];
  assign rlbl_o     = lbl_q[addr_i];
  assign dbg_data_o = word_q[dbg_addr_i];
  assign dbg_lbl_o  = lbl_q[dbg_addr_i];
endmodule

// File: rtl/pred_taint_core.sv
module pred_taint_core
  import ptt_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREG  = 8,
  parameter int DEPTH = 16,
  parameter int PCW   = 8,
  localparam int RW   = $clog2(NREG),
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = 3 + 1 + 3 * RW + DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid_i,
  input  logic [IW-1:0]   instr_i,
  input  logic            instr_lbl_i,
  input  logic [RW-1:0]   dbg_reg_sel_i,
  input  logic [AW-1:0]   dbg_mem_sel_i,
  output logic [PCW-1:0]  pc_o,
  output logic            pc_taint_o,
  output logic            illegal_o,
  output logic            pred_o,
  output logic            pred_lbl_o,
  output logic [NREG-1:0] reg_lbls_o,
  output logic [DW-1:0]   dbg_reg_data_o,
  output logic            dbg_reg_lbl_o,
  output logic [DW-1:0]   dbg_mem_data_o,
  output logic            dbg_mem_lbl_o
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // decode
  logic          pbit, wr_reg, wr_mem, wr_pred, dec_illegal;
  logic [RW-1:0] rd, rs, rt;
  logic [DW-1:0] imm;
  logic [AW-1:0] addr;
  src_e          src;

  ptt_decode #(.DW(DW), .RW(RW), .AW(AW)) i_decode (
    .instr_i  (instr_i),
    .pbit_o   (pbit),
    .rd_o     (rd),
    .rs_o     (rs),
    .rt_o     (rt),
    .imm_o    (imm),
    .addr_o   (addr),
    .src_o    (src),
    .wr_reg_o (wr_reg),
    .wr_mem_o (wr_mem),
    .wr_pred_o(wr_pred),
    .illegal_o(dec_illegal)
  );

  // predicate and its label
  logic p_q, pl_q, p_d, pl_d, p_en;
  logic guard_ok, guard_lbl;

  assign guard_ok  = ~pbit | p_q;
  assign guard_lbl = pbit & pl_q;

  // register file
  logic [DW-1:0] rs_val, rt_val, mem_val, src_val;
  logic          rs_lbl, rt_lbl, rd_old_lbl, mem_lbl, src_lbl;
  logic          reg_wen, reg_wlbl;

  ptt_regfile #(.DW(DW), .NREG(NREG)) i_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wen_i     (reg_wen),
    .waddr_i   (rd),
    .wdata_en_i(guard_ok),
    .wdata_i   (src_val),
    .wlbl_i    (reg_wlbl),
    .ra_a_i    (rs),
    .ra_b_i    (rt),
    .ra_c_i    (rd),
    .ra_d_i    (dbg_reg_sel_i),
    .rd_a_o    (rs_val),
    .rl_a_o    (rs_lbl),
    .rd_b_o    (rt_val),
    .rl_b_o    (rt_lbl),
    .rl_c_o    (rd_old_lbl),
    .rd_d_o    (dbg_reg_data_o),
    .rl_d_o    (dbg_reg_lbl_o),
    .lbls_o    (reg_lbls_o)
  );

  // data memory
  logic mem_wen, mem_wlbl;

  ptt_dmem #(.DW(DW), .DEPTH(DEPTH)) i_dmem (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wen_i     (mem_wen),
    .addr_i    (addr),
    .wdata_en_i(guard_ok),
    .wdata_i   (rs_val),
    .wlbl_i    (mem_wlbl),
    .dbg_addr_i(dbg_mem_sel_i),
    .rdata_o   (mem_val),
    .rlbl_o    (mem_lbl),
    .dbg_data_o(dbg_mem_data_o),
    .dbg_lbl_o (dbg_mem_lbl_o)
  );

  // source selection: a direct address carries the immediate's label
  always_comb begin
    case (src)
      SRC_REG: begin
        src_val = rs_val;
        src_lbl = rs_lbl;
      end
      SRC_MEM: begin
        src_val = mem_val;
        src_lbl = mem_lbl | instr_lbl_i;
      end
      default: begin
        src_val = imm;
        src_lbl = instr_lbl_i;
      end
    endcase
  end

  // a held-back write still reveals the guard, so its label is kept
  assign reg_wen  = instr_valid_i & wr_reg;
  assign reg_wlbl = guard_ok ? (src_lbl | guard_lbl) : (rd_old_lbl | guard_lbl);
  assign mem_wen  = instr_valid_i & wr_mem;
  assign mem_wlbl = guard_ok ? (rs_lbl | instr_lbl_i | guard_lbl)
                             : (mem_lbl | guard_lbl);

  // predicate next state
  assign p_en = instr_valid_i & wr_pred;
  always_comb begin
    p_d  = p_q;
    pl_d = pl_q;
    if (p_en) begin
      p_d  = (rs_val == rt_val);
      pl_d = rs_lbl | rt_lbl;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p_q  <= 1'b0;
      pl_q <= 1'b0;
    end else if (p_en) begin
      p_q  <= p_d;
      pl_q <= pl_d;
    end
  end

  // program counter: the only source of the next PC is the fixed step,
  // whose label is constant-clean, so its label never rises
  logic [PCW-1:0] pc_q, pc_d;
  logic           pc_lbl_q, pc_lbl_d, step_lbl;
  logic           illegal_q, illegal_d;

  assign step_lbl  = 1'b0;
  assign pc_d      = pc_q + PCW'(1);
  assign pc_lbl_d  = pc_lbl_q | step_lbl;
  assign illegal_d = instr_valid_i & dec_illegal;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q     <= '0;
      pc_lbl_q <= 1'b0;
    end else if (instr_valid_i) begin
      pc_q     <= pc_d;
      pc_lbl_q <= pc_lbl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) illegal_q <= 1'b0;
    else             illegal_q <= illegal_d;
  end

  assign pc_o       = pc_q;
  assign pc_taint_o = pc_lbl_q;
  assign illegal_o  = illegal_q;
  assign pred_o     = p_q;
  assign pred_lbl_o = pl_q;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int PCW  = 8,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = 3 + 1 + 3 * RW + DW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid_i,
  input logic [IW-1:0]   instr_i,
  input logic            instr_lbl_i,
  input logic [PCW-1:0]  pc_o,
  input logic            pc_taint_o,
  input logic            illegal_o,
  input logic            pred_lbl_o,
  input logic [NREG-1:0] reg_lbls_o
);
  localparam int OP_LSB = IW - 3;
  localparam int PB_POS = OP_LSB - 1;
  localparam int RD_LSB = PB_POS - RW;
  localparam int RS_LSB = RD_LSB - RW;
  localparam int RT_LSB = RS_LSB - RW;

  logic [2:0]    op_f;
  logic          pb_f;
  logic [RW-1:0] rd_f, rs_f, rt_f;
  logic          is_write;

  assign op_f     = instr_i[IW-1:OP_LSB];
  assign pb_f     = instr_i[PB_POS];
  assign rd_f     = instr_i[RD_LSB +: RW];
  assign rs_f     = instr_i[RS_LSB +: RW];
  assign rt_f     = instr_i[RT_LSB +: RW];
  assign is_write = (op_f == 3'd1) || (op_f == 3'd2) || (op_f == 3'd4);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i |=> pc_o == $past(pc_o) + PCW'(1));

  // R8
  pc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_taint_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> $stable(reg_lbls_o) && $stable(pred_lbl_o) && $stable(pc_o));

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && (op_f >= 3'd6) |=> illegal_o && $stable(reg_lbls_o) && $stable(pred_lbl_o));

  // R2
  movi_lbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && (op_f == 3'd1) && !pb_f |=> reg_lbls_o[$past(rd_f)] == $past(instr_lbl_i));

  // R3
  cmp_lbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && (op_f == 3'd3) && !pb_f |=> pred_lbl_o == $past(reg_lbls_o[rs_f] | reg_lbls_o[rt_f]));

  // R5
  guard_taint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && pb_f && is_write && pred_lbl_o |=> reg_lbls_o[$past(rd_f)]);
endmodule

bind pred_taint_core ptt_checker #(.DW(DW), .NREG(NREG), .PCW(PCW)) i_ptt_checker (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .instr_valid_i(instr_valid_i),
  .instr_i      (instr_i),
  .instr_lbl_i  (instr_lbl_i),
  .pc_o         (pc_o),
  .pc_taint_o   (pc_taint_o),
  .illegal_o    (illegal_o),
  .pred_lbl_o   (pred_lbl_o),
  .reg_lbls_o   (reg_lbls_o)
);

// File: tb/test_pred_taint_core.sv
`timescale 1ns/1ps
module test_pred_taint_core;
  localparam int DW = 8, NREG = 8, DEPTH = 16, PCW = 8;
  localparam int RW = 3, AW = 4, IW = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic instr_valid_i;
  logic [IW-1:0] instr_i;
  logic instr_lbl_i;
  logic [RW-1:0] dbg_reg_sel_i;
  logic [AW-1:0] dbg_mem_sel_i;
  logic [PCW-1:0] pc_o;
  logic pc_taint_o, illegal_o, pred_o, pred_lbl_o;
  logic [NREG-1:0] reg_lbls_o;
  logic [DW-1:0] dbg_reg_data_o, dbg_mem_data_o;
  logic dbg_reg_lbl_o, dbg_mem_lbl_o;

  always #2 clk = ~clk;

  pred_taint_core #(.DW(DW), .NREG(NREG), .DEPTH(DEPTH), .PCW(PCW)) i_pred_taint_core (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .instr_lbl_i(instr_lbl_i), .dbg_reg_sel_i(dbg_reg_sel_i), .dbg_mem_sel_i(dbg_mem_sel_i),
    .pc_o(pc_o), .pc_taint_o(pc_taint_o), .illegal_o(illegal_o), .pred_o(pred_o),
    .pred_lbl_o(pred_lbl_o), .reg_lbls_o(reg_lbls_o), .dbg_reg_data_o(dbg_reg_data_o),
    .dbg_reg_lbl_o(dbg_reg_lbl_o), .dbg_mem_data_o(dbg_mem_data_o), .dbg_mem_lbl_o(dbg_mem_lbl_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_r [NREG];
  logic [NREG-1:0] m_l;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DEPTH-1:0] m_ml;
  logic m_p, m_pl, m_ill;
  logic [PCW-1:0] m_pc;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " labels"}, 32'(reg_lbls_o), 32'(m_l));
    chk({req, " pred"}, 32'(pred_o), 32'(m_p));
    chk({req, " pred label"}, 32'(pred_lbl_o), 32'(m_pl));
    chk({req, " R8 pc"}, 32'(pc_o), 32'(m_pc));
    chk({req, " R8 pc label"}, 32'(pc_taint_o), 32'd0);
    chk({req, " illegal"}, 32'(illegal_o), 32'(m_ill));
    for (int i = 0; i < NREG; i++) begin
      dbg_reg_sel_i = RW'(i);
      #0.2;
      chk({req, " reg value"}, 32'(dbg_reg_data_o), 32'(m_r[i]));
    end
  endtask

  task automatic chk_mem(string req, int a);
    dbg_mem_sel_i = AW'(a);
    #0.2;
    chk({req, " mem value"}, 32'(dbg_mem_data_o), 32'(m_mem[a]));
    chk({req, " mem label"}, 32'(dbg_mem_lbl_o), 32'(m_ml[a]));
  endtask

  // issue one instruction at a falling edge, check at the next one
  task automatic issue(string req, logic [2:0] op, logic pb, int rd, int rs, int rt,
                       logic [7:0] imm, logic lbl);
    logic ex, gl;
    logic [DW-1:0] sv;
    logic sl;
    int a;
    instr_i       = {op, pb, RW'(rd), RW'(rs), RW'(rt), imm};
    instr_lbl_i   = lbl;
    instr_valid_i = 1'b1;
    a  = int'(imm[AW-1:0]);
    ex = !pb || m_p;
    gl = pb && m_pl;
    m_ill = (op >= 3'd6) || (op == 3'd3 && pb);
    sv = '0; sl = 1'b0;
    if (!m_ill) begin
      case (op)
        3'd1: begin sv = imm; sl = lbl; end
        3'd2: begin sv = m_r[rs]; sl = m_l[rs]; end
        3'd4: begin sv = m_mem[a]; sl = m_ml[a] | lbl; end
        default: ;
      endcase
      if (op == 3'd1 || op == 3'd2 || op == 3'd4) begin
        if (ex) m_r[rd] = sv;
        m_l[rd] = ex ? (sl | gl) : (m_l[rd] | gl);
      end else if (op == 3'd3) begin
        m_p  = (m_r[rs] == m_r[rt]);
        m_pl = m_l[rs] | m_l[rt];
      end else if (op == 3'd5) begin
        m_ml[a] = ex ? (m_l[rs] | lbl | gl) : (m_ml[a] | gl);
        if (ex) m_mem[a] = m_r[rs];
      end
    end
    m_pc = m_pc + 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
    chk_all(req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) begin m_r[i] = '0; end
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; end
    m_l = '0; m_ml = '0; m_p = 0; m_pl = 0; m_ill = 0; m_pc = '0;
    chk_all("R1 reset");
    for (int i = 0; i < DEPTH; i++) chk_mem("R1 reset", i);
  endtask

  task automatic t_movi;
    issue("R2 movi clean", 3'd1, 0, 1, 0, 0, 8'h05, 0);
    issue("R2 movi secret", 3'd1, 0, 2, 0, 0, 8'h5A, 1);
    issue("R2 movi clean 2", 3'd1, 0, 3, 0, 0, 8'h05, 0);
  endtask

  task automatic t_cmp_false_guard;
    issue("R3 cmp secret", 3'd3, 0, 0, 2, 3, 8'h00, 0);
    issue("R5 guarded movi false", 3'd1, 1, 4, 0, 0, 8'h07, 0);
    issue("R5 guarded mov false", 3'd2, 1, 5, 1, 0, 8'h00, 0);
    issue("R2 const after tainted pred", 3'd1, 0, 4, 0, 0, 8'h05, 0);
  endtask

  task automatic t_true_guard;
    issue("R3 cmp clean", 3'd3, 0, 0, 1, 3, 8'h00, 0);
    issue("R4 guarded mov true", 3'd2, 1, 6, 2, 0, 8'h00, 0);
    issue("R3 cmp self secret", 3'd3, 0, 0, 2, 2, 8'h00, 0);
    issue("R4 guarded movi true tainted pred", 3'd1, 1, 7, 0, 0, 8'h09, 0);
  endtask

  task automatic t_mem;
    issue("R7 store clean", 3'd5, 0, 0, 1, 0, 8'h03, 0);
    chk_mem("R7 store clean", 3);
    issue("R6 load clean", 3'd4, 0, 0, 0, 0, 8'h03, 0);
    issue("R6 load tainted address", 3'd4, 0, 0, 0, 0, 8'h03, 1);
    issue("R7 store secret", 3'd5, 0, 0, 2, 0, 8'h04, 0);
    chk_mem("R7 store secret", 4);
    issue("R6 load tainted word", 3'd4, 0, 5, 0, 0, 8'h04, 0);
    issue("R3 cmp to false", 3'd3, 0, 0, 1, 2, 8'h00, 0);
    issue("R7 guarded store false", 3'd5, 1, 0, 3, 0, 8'h03, 0);
    chk_mem("R7 guarded store false", 3);
    issue("R6 guarded load false", 3'd4, 1, 1, 0, 0, 8'h04, 0);
  endtask

  task automatic t_illegal;
    issue("R9 jump", 3'd6, 0, 1, 2, 3, 8'h0F, 1);
    issue("R9 indirect load", 3'd7, 0, 3, 2, 0, 8'h04, 1);
    issue("R9 guarded cmp", 3'd3, 1, 0, 1, 1, 8'h00, 0);
    issue("R9 legal after illegal", 3'd0, 0, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic t_idle;
    instr_i = {3'd1, 1'b0, 3'd1, 3'd0, 3'd0, 8'hEE};
    instr_lbl_i = 1'b1;
    repeat (3) @(negedge clk);
    m_ill = 0;
    chk_all("R10 idle");
    chk_mem("R10 idle", 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_valid_i = 1'b0;
    instr_i = '0;
    instr_lbl_i = 1'b0;
    dbg_reg_sel_i = '0;
    dbg_mem_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_movi();
    t_cmp_false_guard();
    t_true_guard();
    t_mem();
    t_illegal();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule